// File: doc/BRIEF.md
# Packed SIMD Saturating Fixed-Point ALU

This block is a datapath that treats each 32-bit operand pair as packed lanes and applies one lane-wise operation per accepted cycle. The lane layout is chosen per operation: four unsigned 8-bit lanes, two signed 16-bit Q15 fractions, or one signed 32-bit Q31 fraction. Q15 and Q31 values are signed fractions from -1 up to just below +1. Each lane can add, subtract, shift left, shift right arithmetically or shift right logically. When saturation is requested, an overflowing lane returns the representable value nearest to the exact answer instead of wrapping.

A separate multiply-accumulate operation multiplies the low Q15 halves of the operands, aligns the fractional point and adds the product into one of four 64-bit accumulators. Each operation reports a flag per lane, and a sticky copy of those flags collects overflow history until a clear input is pulsed. Results and flags leave through registers, one cycle after the operation is accepted. The block sits beside an integer pipeline. Decode, register file and memory access are handled by the surrounding logic.

Top module: `simd_sat_alu`

## Requirements
- R1: While `rst_n` is low, `result_o`, `lane_ovf_o` and `sticky_ovf_o` are zero, and all four accumulators are zero, so `acc_o` reads zero for every `acc_sel_i`.
- R2: In mode 0 the operands are four unsigned bytes, with lane k at bits [8k+7:8k] and its flag at `lane_ovf_o[k]`. Op 0 (add) and op 1 (subtract) flag a lane whose exact result lies outside 0..255. The lane wraps modulo 256 when `sat_i`=0 and is clamped to 0 or 255 when `sat_i`=1.
- R3: In mode 1 the operands are two signed Q15 lanes, with lane k at bits [16k+15:16k] and its flag at `lane_ovf_o[k]`; `lane_ovf_o[3:2]` stay zero. A lane whose add or subtract falls outside -32768..32767 is flagged, and it saturates to 0x8000 or 0x7FFF when `sat_i`=1 or wraps otherwise.
- R4: In modes 2 and 3 the operands form one signed Q31 lane. Overflow sets `lane_ovf_o[0]` only, and saturation gives 0x80000000 or 0x7FFFFFFF.
- R5: Op 2 shifts each lane left by `shamt_i` modulo the lane width. The lane is flagged when the shifted value cannot represent the exact product of the lane value and 2^amount. With `sat_i`=1 it then returns the maximum (255, 0x7FFF or 0x7FFFFFFF) for a non-negative lane value or the signed minimum for a negative one.
- R6: Op 3 shifts right with sign fill in signed lanes and zero fill in byte lanes, and op 4 shifts right with zero fill. Both use `shamt_i` modulo the lane width, and neither ever sets a flag.
- R7: Op 5 (multiply-accumulate) ignores `mode_i`, `sat_i` and operand bits [31:16]. It forms the signed product of `a_i[15:0]` and `b_i[15:0]` doubled. When both are 0x8000 the product is 0x7FFFFFFF and `lane_ovf_o[0]` is set. `result_o` shows the product and `lane_ovf_o[3:1]` are zero.
- R8: Op 5 adds the sign-extended product to the accumulator chosen by `acc_sel_i`, wrapping modulo 2^64, and leaves the other three unchanged. `acc_o` reads the accumulator chosen by `acc_sel_i`.
- R9: An operation with `valid_i`=1 appears on `result_o` and `lane_ovf_o` after the next rising clock edge. While `valid_i`=0 those outputs hold and no accumulator changes.
- R10: `sticky_ovf_o` ORs in the lane flags of each accepted operation. A cycle with `flag_clr_i`=1 leaves it zero, even when an overflowing operation is accepted in the same cycle.
- R11: Op codes 6 and 7 produce a zero result with no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Accept the operation presented this cycle |
| op_i | input | 3 | 0 add, 1 sub, 2 shift left, 3 shift right arithmetic, 4 shift right logical, 5 Q15 multiply-accumulate |
| mode_i | input | 2 | Lane layout: 0 four bytes, 1 two Q15, 2 or 3 one Q31 |
| sat_i | input | 1 | Clamp overflowing lanes instead of wrapping |
| shamt_i | input | 5 | Shift amount, reduced modulo the lane width |
| acc_sel_i | input | 2 | Accumulator to update and to read |
| a_i | input | 32 | First packed operand |
| b_i | input | 32 | Second packed operand |
| flag_clr_i | input | 1 | Clear the sticky overflow flags |
| result_o | output | 32 | Registered packed result |
| lane_ovf_o | output | 4 | Registered per-lane overflow flags |
| sticky_ovf_o | output | 4 | Accumulated overflow flags |
| acc_o | output | 64 | Content of the selected accumulator |

## Verification
The bench sweeps byte, Q15 and Q31 operand grids that straddle each lane's limits and compares every lane against exact integer arithmetic. A design that clamps on the wrong side, takes the carry out of the wrong bit, or lets a carry cross from one lane into the next gives a wrong value in one lane and leaves its neighbours correct. Every shift amount is applied in every lane width. This catches a shift amount that is not reduced per lane, a right shift that fills signed lanes with zeros, and a left shift that misses lost sign bits. The multiply-accumulate tests cover the -1 times -1 product, which would otherwise wrap to -1, and they cover updates that reach the wrong accumulator. The bench also accepts an overflowing operation in the same cycle as a clear, to show that the clear takes precedence in the sticky flags.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned N_BYTE = WORD_W / BYTE_W;
  localparam int unsigned N_HALF = WORD_W / HALF_W;
  localparam int unsigned PROD_W = 2 * HALF_W;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_SHL  = 3'd2,
    OP_SHRA = 3'd3,
    OP_SHRL = 3'd4,
    OP_MAC  = 3'd5
  } alu_op_e;

  typedef enum logic [1:0] {
    LM_U8  = 2'd0,
    LM_Q15 = 2'd1,
    LM_Q31 = 2'd2,
    LM_Q31X = 2'd3
  } lane_mode_e;

  typedef struct packed {
    logic [PROD_W-1:0] term;
    logic              ovf;
  } mac_term_t;

  // Q15 x Q15 -> Q31 with the single unrepresentable case clamped
  function automatic mac_term_t q15_product(input logic [HALF_W-1:0] a,
                                            input logic [HALF_W-1:0] b);
    mac_term_t         r;
    logic signed [PROD_W-1:0] ax;
    logic signed [PROD_W-1:0] bx;
    logic signed [PROD_W-1:0] p;
    ax = {{HALF_W{a[HALF_W-1]}}, a};
    bx = {{HALF_W{b[HALF_W-1]}}, b};
    p  = ax * bx;
    if (a == {1'b1, {(HALF_W-1){1'b0}}} && b == {1'b1, {(HALF_W-1){1'b0}}}) begin
      r.term = {1'b0, {(PROD_W-1){1'b1}}};
      r.ovf  = 1'b1;
    end else begin
      r.term = {p[PROD_W-2:0], 1'b0};
      r.ovf  = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_alu_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter bit          SIGNED_LANE = 1'b0,
  localparam int unsigned SH_W       = $clog2(W)
) (
  input  logic [2:0]      op_i,
  input  logic            sat_i,
  input  logic [SH_W-1:0] sh_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  output logic [W-1:0]    res_o,
  output logic            ovf_o
);

  localparam logic [W-1:0] UMAX = {W{1'b1}};
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic          ext_a, ext_b;
  logic [W:0]    add_x, sub_x;
  logic          add_ovf, sub_ovf, shl_ovf;
  logic [W-1:0]  add_sat, sub_sat, shl_sat;
  logic [W-1:0]  shl_x, shl_back, shra_x, shrl_x;

  always_comb begin
    ext_a = SIGNED_LANE ? a_i[W-1] : 1'b0;
    ext_b = SIGNED_LANE ? b_i[W-1] : 1'b0;
    add_x = {ext_a, a_i} + {ext_b, b_i};
    sub_x = {ext_a, a_i} - {ext_b, b_i};

    if (SIGNED_LANE) begin
      add_ovf = add_x[W] ^ add_x[W-1];
      sub_ovf = sub_x[W] ^ sub_x[W-1];
      add_sat = add_x[W] ? SMIN : SMAX;
      sub_sat = sub_x[W] ? SMIN : SMAX;
    end else begin
      add_ovf = add_x[W];
      sub_ovf = sub_x[W];
      add_sat = UMAX;
      sub_sat = '0;
    end

    shl_x = a_i << sh_i;
    if (SIGNED_LANE) begin
      shl_back = $signed(shl_x) >>> sh_i;
      shl_sat  = a_i[W-1] ? SMIN : SMAX;
      shra_x   = $signed(a_i) >>> sh_i;
    end else begin
      shl_back = shl_x >> sh_i;
      shl_sat  = UMAX;
      shra_x   = a_i >> sh_i;
    end
    shl_ovf = (shl_back != a_i);
    shrl_x  = a_i >> sh_i;

    res_o = '0;
    ovf_o = 1'b0;
    case (op_i)
      OP_ADD: begin
        res_o = (add_ovf && sat_i) ? add_sat : add_x[W-1:0];
        ovf_o = add_ovf;
      end
      OP_SUB: begin
        res_o = (sub_ovf && sat_i) ? sub_sat : sub_x[W-1:0];
        ovf_o = sub_ovf;
      end
      OP_SHL: begin
        res_o = (shl_ovf && sat_i) ? shl_sat : shl_x;
        ovf_o = shl_ovf;
      end
      OP_SHRA: res_o = shra_x;
      OP_SHRL: res_o = shrl_x;
      default: begin
        res_o = '0;
        ovf_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/simd_mac_unit.sv
module simd_mac_unit
  import simd_alu_pkg::*;
#(
  parameter int unsigned ACC_W = 64
) (
  input  logic [HALF_W-1:0] a_i,
  input  logic [HALF_W-1:0] b_i,
  input  logic [ACC_W-1:0]  acc_i,
  output logic [PROD_W-1:0] term_o,
  output logic              ovf_o,
  output logic [ACC_W-1:0]  acc_o
);

  mac_term_t prod;

  always_comb begin
    prod   = q15_product(a_i, b_i);
    term_o = prod.term;
    ovf_o  = prod.ovf;
    acc_o  = acc_i + {{(ACC_W-PROD_W){prod.term[PROD_W-1]}}, prod.term};
  end

endmodule

// File: rtl/simd_acc_bank.sv
module simd_acc_bank #(
  parameter int unsigned ACC_W   = 64,
  parameter int unsigned NUM_ACC = 4,
  localparam int unsigned SEL_W  = $clog2(NUM_ACC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [ACC_W-1:0] wr_data_i,
  output logic [ACC_W-1:0] rd_data_o
);

  logic [ACC_W-1:0] acc_q [NUM_ACC];

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[g] <= '0;
      end else if (wr_en_i && sel_i == SEL_W'(g)) begin
        acc_q[g] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = acc_q[sel_i];

endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
  import simd_alu_pkg::*;
#(
  parameter int unsigned ACC_W   = 64,
  parameter int unsigned NUM_ACC = 4,
  localparam int unsigned SEL_W  = $clog2(NUM_ACC),
  localparam int unsigned SHA_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        mode_i,
  input  logic              sat_i,
  input  logic [SHA_W-1:0]  shamt_i,
  input  logic [SEL_W-1:0]  acc_sel_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              flag_clr_i,
  output logic [WORD_W-1:0] result_o,
  output logic [N_BYTE-1:0] lane_ovf_o,
  output logic [N_BYTE-1:0] sticky_ovf_o,
  output logic [ACC_W-1:0]  acc_o
);

  localparam int unsigned BSH_W = $clog2(BYTE_W);
  localparam int unsigned HSH_W = $clog2(HALF_W);

  // lane results for each layout
  logic [WORD_W-1:0] u8_res, q15_res, q31_res;
  logic [N_BYTE-1:0] u8_ovf;
  logic [N_HALF-1:0] q15_ovf;
  logic              q31_ovf;

  // named internal events
  logic              mac_fire;
  logic              acc_wr_en;
  logic [PROD_W-1:0] mac_term;
  logic              mac_ovf;
  logic [ACC_W-1:0]  acc_sum;
  logic [WORD_W-1:0] res_nxt;
  logic [N_BYTE-1:0] lane_ovf_nxt;

  for (genvar g = 0; g < N_BYTE; g++) begin : g_byte
    simd_lane #(.W(BYTE_W), .SIGNED_LANE(1'b0)) u_lane (
      .op_i  (op_i),
      .sat_i (sat_i),
      .sh_i  (shamt_i[BSH_W-1:0]),
      .a_i   (a_i[g*BYTE_W +: BYTE_W]),
      .b_i   (b_i[g*BYTE_W +: BYTE_W]),
      .res_o (u8_res[g*BYTE_W +: BYTE_W]),
      .ovf_o (u8_ovf[g])
    );
  end

  for (genvar g = 0; g < N_HALF; g++) begin : g_half
    simd_lane #(.W(HALF_W), .SIGNED_LANE(1'b1)) u_lane (
      .op_i  (op_i),
      .sat_i (sat_i),
      .sh_i  (shamt_i[HSH_W-1:0]),
      .a_i   (a_i[g*HALF_W +: HALF_W]),
      .b_i   (b_i[g*HALF_W +: HALF_W]),
      .res_o (q15_res[g*HALF_W +: HALF_W]),
      .ovf_o (q15_ovf[g])
    );
  end

  simd_lane #(.W(WORD_W), .SIGNED_LANE(1'b1)) u_word (
    .op_i  (op_i),
    .sat_i (sat_i),
    .sh_i  (shamt_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (q31_res),
    .ovf_o (q31_ovf)
  );

  simd_mac_unit #(.ACC_W(ACC_W)) u_mac (
    .a_i    (a_i[HALF_W-1:0]),
    .b_i    (b_i[HALF_W-1:0]),
    .acc_i  (acc_o),
    .term_o (mac_term),
    .ovf_o  (mac_ovf),
    .acc_o  (acc_sum)
  );

  assign mac_fire  = (op_i == OP_MAC);
  assign acc_wr_en = valid_i && mac_fire;

  simd_acc_bank #(.ACC_W(ACC_W), .NUM_ACC(NUM_ACC)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (acc_wr_en),
    .sel_i     (acc_sel_i),
    .wr_data_i (acc_sum),
    .rd_data_o (acc_o)
  );

  always_comb begin
    if (mac_fire) begin
      res_nxt      = mac_term;
      lane_ovf_nxt = {{(N_BYTE-1){1'b0}}, mac_ovf};
    end else begin
      case (mode_i)
        LM_U8: begin
          res_nxt      = u8_res;
          lane_ovf_nxt = u8_ovf;
        end
        LM_Q15: begin
          res_nxt      = q15_res;
          lane_ovf_nxt = {{(N_BYTE-N_HALF){1'b0}}, q15_ovf};
        end
        default: begin
          res_nxt      = q31_res;
          lane_ovf_nxt = {{(N_BYTE-1){1'b0}}, q31_ovf};
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o     <= '0;
      lane_ovf_o   <= '0;
      sticky_ovf_o <= '0;
    end else begin
      if (valid_i) begin
        result_o   <= res_nxt;
        lane_ovf_o <= lane_ovf_nxt;
      end
      if (flag_clr_i) begin
        sticky_ovf_o <= '0;
      end else if (valid_i) begin
        sticky_ovf_o <= sticky_ovf_o | lane_ovf_nxt;
      end
    end
  end

endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid_i,
  input logic [2:0]  op_i,
  input logic [1:0]  mode_i,
  input logic        sat_i,
  input logic [15:0] a_lo_i,
  input logic [15:0] b_lo_i,
  input logic        flag_clr_i,
  input logic        mac_fire,
  input logic [31:0] result_o,
  input logic [3:0]  lane_ovf_o,
  input logic [3:0]  sticky_ovf_o
);

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr_i |=> sticky_ovf_o == 4'b0000); // R10

  AST_STICKY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_clr_i |=> ($past(sticky_ovf_o) & ~sticky_ovf_o) == 4'b0000); // R10

  AST_STICKY_GATHERS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !flag_clr_i) |=> (lane_ovf_o & ~sticky_ovf_o) == 4'b0000); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(result_o) && $stable(lane_ovf_o)); // R9

  AST_RSHIFT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (op_i == 3'd3 || op_i == 3'd4)) |=> lane_ovf_o == 4'b0000); // R6

  AST_WIDE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (op_i == 3'd5 || mode_i[1])) |=> lane_ovf_o[3:1] == 3'b000); // R4

  AST_Q15_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mode_i == 2'd1 && op_i != 3'd5) |=> lane_ovf_o[3:2] == 2'b00); // R3

  AST_U8_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mode_i == 2'd0 && op_i == 3'd0 && sat_i)
      |=> (!lane_ovf_o[0] || result_o[7:0] == 8'hFF)); // R2

  AST_MAC_NEG_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mac_fire && a_lo_i == 16'h8000 && b_lo_i == 16'h8000)
      |=> (result_o == 32'h7FFF_FFFF && lane_ovf_o[0])); // R7

endmodule

bind simd_sat_alu simd_alu_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .valid_i      (valid_i),
  .op_i         (op_i),
  .mode_i       (mode_i),
  .sat_i        (sat_i),
  .a_lo_i       (a_i[15:0]),
  .b_lo_i       (b_i[15:0]),
  .flag_clr_i   (flag_clr_i),
  .mac_fire     (mac_fire),
  .result_o     (result_o),
  .lane_ovf_o   (lane_ovf_o),
  .sticky_ovf_o (sticky_ovf_o)
);

// File: tb/tb_simd_sat_alu.sv
`timescale 1ns/1ps
module tb_simd_sat_alu;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i, sat_i, flag_clr_i;
  logic [2:0]  op_i;
  logic [1:0]  mode_i, acc_sel_i;
  logic [4:0]  shamt_i;
  logic [31:0] a_i, b_i, result_o;
  logic [3:0]  lane_ovf_o, sticky_ovf_o;
  logic [63:0] acc_o;

  always #2.5 clk = ~clk;

  simd_sat_alu dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .mode_i(mode_i),
    .sat_i(sat_i), .shamt_i(shamt_i), .acc_sel_i(acc_sel_i), .a_i(a_i), .b_i(b_i),
    .flag_clr_i(flag_clr_i), .result_o(result_o), .lane_ovf_o(lane_ovf_o),
    .sticky_ovf_o(sticky_ovf_o), .acc_o(acc_o)
  );

  int          n_chk  = 0;
  int          n_fail = 0;
  bit          done   = 0;
  logic [63:0] acc_m [4];
  logic [3:0]  st_m;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // exact-integer lane reference
  function automatic void lane_ref(input int w, input bit sgn, input int op, input bit sat,
                                   input longint ua, input longint ub, input int sh,
                                   output longint r, output bit o);
    longint mask = (longint'(1) << w) - 1;
    longint sa = (sgn && ((ua >> (w-1)) & 1) == 1) ? ua - (longint'(1) << w) : ua;
    longint sb = (sgn && ((ub >> (w-1)) & 1) == 1) ? ub - (longint'(1) << w) : ub;
    longint hi = sgn ? (longint'(1) << (w-1)) - 1 : mask;
    longint lo = sgn ? -(longint'(1) << (w-1)) : 0;
    longint v;
    r = 0; o = 0;
    if (op <= 2) begin
      v = (op == 0) ? sa + sb : (op == 1) ? sa - sb : sa * (longint'(1) << sh);
      o = (v > hi) || (v < lo);
      r = (o && sat) ? ((v > hi) ? hi : lo) & mask : v & mask;
    end else if (op == 3) begin
      r = (sgn ? (sa >>> sh) : (ua >> sh)) & mask;
    end else if (op == 4) begin
      r = ua >> sh;
    end
  endfunction

  function automatic void word_ref(input int op, input int mode, input bit sat, input int shamt,
                                   input logic [31:0] a, input logic [31:0] b,
                                   output logic [31:0] r, output logic [3:0] f);
    int w = (mode == 0) ? 8 : (mode == 1) ? 16 : 32;
    longint mask = (longint'(1) << w) - 1;
    longint lr;
    bit lo;
    r = '0; f = '0;
    for (int k = 0; k < 32 / w; k++) begin
      lane_ref(w, mode != 0, op, sat, (longint'(a) >> (k*w)) & mask,
               (longint'(b) >> (k*w)) & mask, shamt % w, lr, lo);
      r = r | (32'(lr) << (k*w));
      f[k] = lo;
    end
  endfunction

  task automatic run(input int op, input int mode, input bit sat, input int shamt,
                     input logic [31:0] a, input logic [31:0] b, input int sel, input string tag);
    logic [31:0] er;
    logic [3:0]  ef;
    longint      p;
    if (op == 5) begin
      p = longint'($signed(a[15:0])) * longint'($signed(b[15:0])) * 2;
      if (p == 64'sd2147483648) begin er = 32'h7FFF_FFFF; ef = 4'b0001; end
      else begin er = p[31:0]; ef = 4'b0000; end
      acc_m[sel] = acc_m[sel] + {{32{er[31]}}, er};
    end else begin
      word_ref(op, mode, sat, shamt, a, b, er, ef);
    end
    st_m = st_m | ef;
    op_i = 3'(op); mode_i = 2'(mode); sat_i = sat; shamt_i = 5'(shamt);
    a_i = a; b_i = b; acc_sel_i = 2'(sel); valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk(result_o == er,       {tag, " result"}, 64'(result_o), 64'(er));
    chk(lane_ovf_o == ef,     {tag, " flags"},  64'(lane_ovf_o), 64'(ef));
    chk(sticky_ovf_o == st_m, "R10 sticky",     64'(sticky_ovf_o), 64'(st_m));
    chk(acc_o == acc_m[sel],  "R8 accumulator", acc_o, acc_m[sel]);
  endtask

  task automatic clear_flags();
    flag_clr_i = 1'b1;
    @(negedge clk);
    flag_clr_i = 1'b0;
    st_m = '0;
    chk(sticky_ovf_o == 4'b0, "R10 clear", 64'(sticky_ovf_o), 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  bv;
    logic [7:0]  cv;
    logic [15:0] q15v [10] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'h8001,
                               16'hFFFF, 16'h4000, 16'hC000, 16'h3FFF, 16'h1234};
    logic [31:0] q31v [8]  = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000,
                               32'h8000_0001, 32'hFFFF_FFFF, 32'h4000_0000, 32'hC000_0000};
    logic [31:0] shv  [5]  = '{32'h0000_0001, 32'h8000_0000, 32'h7F01_C0FF,
                               32'hFFFF_FFFF, 32'h4000_BFFF};
    logic [31:0] keep_r;
    logic [3:0]  keep_f;

    rst_n = 1'b0; valid_i = 0; op_i = 0; mode_i = 0; sat_i = 0; shamt_i = 0;
    acc_sel_i = 0; a_i = 0; b_i = 0; flag_clr_i = 0; st_m = '0;
    for (int s = 0; s < 4; s++) acc_m[s] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(result_o == 32'h0,  "R1 result",  64'(result_o), 64'h0);
    chk(lane_ovf_o == 4'h0, "R1 flags",   64'(lane_ovf_o), 64'h0);
    chk(sticky_ovf_o == 4'h0, "R1 sticky", 64'(sticky_ovf_o), 64'h0);
    for (int s = 0; s < 4; s++) begin
      acc_sel_i = 2'(s);
      #1;
      chk(acc_o == 64'h0, "R1 accumulator", acc_o, 64'h0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: byte lanes, add/sub, wrap and clamp
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        bv = 8'(i * 17);
        cv = 8'(j * 17);
        for (int op = 0; op < 2; op++) begin
          for (int s = 0; s < 2; s++) begin
            run(op, 0, s[0], 0, {bv, cv, ~bv, bv ^ cv}, {cv, bv, cv, ~cv}, 0, "R2");
          end
        end
      end
    end
    clear_flags();

    // R3: Q15 lanes
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 10; j++)
        for (int op = 0; op < 2; op++)
          for (int s = 0; s < 2; s++)
            run(op, 1, s[0], 0, {q15v[i], q15v[j]}, {q15v[j], q15v[i]}, 1, "R3");

    // R4: Q31 lane, both mode codes
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int op = 0; op < 2; op++)
          for (int s = 0; s < 2; s++)
            run(op, 2 + ((i + j) % 2), s[0], 0, q31v[i], q31v[j], 2, "R4");
    clear_flags();

    // R5 / R6: every shift amount in every lane layout
    for (int mode = 0; mode < 3; mode++)
      for (int op = 2; op < 5; op++)
        for (int s = 0; s < 2; s++)
          for (int sh = 0; sh < 32; sh++)
            for (int k = 0; k < 5; k++)
              run(op, mode, s[0], sh, shv[k], 32'h0, 3, (op == 2) ? "R5" : "R6");

    // R7 / R8: Q15 multiply-accumulate into each accumulator
    for (int sel = 0; sel < 4; sel++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          run(5, (i + sel) % 4, j[0], i, {16'hA5A5 ^ 16'(j), q15v[i]},
              {16'h5A5A ^ 16'(i), q15v[j]}, sel, "R7");
    for (int k = 0; k < 6; k++)
      run(5, 0, 0, 0, 32'h0000_8000, 32'h0000_8000, k % 4, "R7 min-times-min");
    for (int s = 0; s < 4; s++) begin
      acc_sel_i = 2'(s);
      #1;
      chk(acc_o == acc_m[s], "R8 accumulator readback", acc_o, acc_m[s]);
    end
    @(negedge clk);

    // R9: idle cycles hold outputs and accumulators
    run(0, 0, 1, 0, 32'hFF10_2030, 32'h0120_3040, 2, "R9");
    keep_r = result_o;
    keep_f = lane_ovf_o;
    op_i = 3'd5; a_i = 32'h0000_7FFF; b_i = 32'h0000_7FFF; acc_sel_i = 2'd2; valid_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(result_o == keep_r,  "R9 result hold", 64'(result_o), 64'(keep_r));
    chk(lane_ovf_o == keep_f, "R9 flag hold",  64'(lane_ovf_o), 64'(keep_f));
    chk(acc_o == acc_m[2],   "R9 accumulator hold", acc_o, acc_m[2]);

    // R10: clear beats a same-cycle overflow
    clear_flags();
    run(0, 0, 0, 0, 32'h0000_00FF, 32'h0000_0001, 0, "R10 set");
    chk(sticky_ovf_o == 4'b0001, "R10 set", 64'(sticky_ovf_o), 64'h1);
    op_i = 3'd0; mode_i = 2'd0; a_i = 32'hFFFF_FFFF; b_i = 32'h0101_0101;
    valid_i = 1'b1; flag_clr_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0; flag_clr_i = 1'b0; st_m = '0;
    chk(lane_ovf_o == 4'hF,   "R10 flags with clear", 64'(lane_ovf_o), 64'hF);
    chk(sticky_ovf_o == 4'h0, "R10 clear priority",   64'(sticky_ovf_o), 64'h0);
    run(1, 1, 1, 0, 32'h8000_0000, 32'h0001_0000, 0, "R10 later set");

    // R11: unused op codes
    run(6, 0, 1, 3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R11");
    run(7, 2, 0, 5, 32'h8000_0000, 32'h7FFF_FFFF, 1, "R11");

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule